// File: doc/BRIEF.md
# Reset Configuration Pin Sampler

This block sits next to the reset sequencer of a chip. A reset request from any source raises a reset-active output. That output stays high for a fixed number of clocks after the last request. While it is high, the block captures a weak-pull configuration pin and a two-bit boot-mode pin pair, and stores them with the code of the reset source in a status register. Pad logic reads the stored pull setting to choose the default pull direction of the timer pins once reset ends. The boot logic reads the stored boot code.

All capture happens in one cycle: the fourth-to-last cycle of the reset-active window. The boot pins are taken only if the configuration-enable pin is high in that cycle; otherwise a default code is stored. A reset from the debug port, or an external reset requested by software, leaves the stored pull setting as it was. A power-on reset request puts the status register back to its defaults at once, so the register is known before the first capture.

Top module: `rstcfg_sampler`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state: after that edge `rst_active` is 0, `stat_wkp` is 1, `stat_boot` is 2'b00 and `stat_src` is 3'd0 (power-on).
- R2: `rst_active` is 1 from the cycle after a clock edge that sees `rst_req` high. It stays 1 for exactly `LEN` cycles (default 32) after the last such edge, and then returns to 0.
- R3: A new `rst_req` while `rst_active` is 1 restarts the window. An earlier window that is cut short makes no capture.
- R4: `wkp_pin` is sampled in the fourth-to-last cycle of the window. That is the cycle in which `rst_active` has been high for `LEN-4` cycles since the last request edge. The sampled value appears on `stat_wkp` in the next cycle.
- R5: If the pending reset source is debug (3'd3) or software external (3'd5), `stat_wkp` keeps its previous value at the capture point. All other codes refresh it.
- R6: At the capture point, `stat_boot` takes `boot_pins` if `cfg_en` is 1 in that cycle, and 2'b00 otherwise. The codes are: 00 internal flash, 01 serial/CAN download, 10 external memory without arbitration, 11 external memory with external arbitration.
- R7: At the capture point, `stat_src` takes the `rst_src` code of the last request. The codes are: 0 power-on, 1 external pin, 2 watchdog, 3 debug, 4 software system, 5 software external.
- R8: A request with `rst_src` = 3'd0 (power-on) sets `stat_wkp` to 1 and `stat_boot` to 2'b00 in the cycle after the request edge, before any capture.
- R9: At all other times the status outputs hold their value. Between a request and the capture point, changes on `wkp_pin`, `cfg_en` and `boot_pins` do not show on the status outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_req | input | 1 | Reset request pulse from the reset controller |
| rst_src | input | 3 | Source code of the request |
| cfg_en | input | 1 | Qualifies the boot pins |
| boot_pins | input | 2 | Boot-mode pins |
| wkp_pin | input | 1 | Weak-pull configuration pin (1 = pull-up) |
| rst_active | output | 1 | Reset-active window output |
| stat_wkp | output | 1 | Stored pull setting |
| stat_boot | output | 2 | Stored boot code |
| stat_src | output | 3 | Stored reset source code |

## Verification
The bench changes the configuration pins in every cycle of the window. A design that samples one cycle early or late would then store the wrong pull bit or the wrong boot code. It sends debug and software-external resets whose pin value differs from the stored bit, so a design that refreshes the pull setting for every source is caught. It restarts a window in mid-flight with a different source code. A design that does not restart the counter would either let `rst_active` fall too soon or store the code of the first source. It drops `cfg_en` in the capture cycle while the boot pins are non-zero, which exposes a design that ignores the enable. Power-on requests come after non-default values are stored, which exposes a missing early clear.

// File: rtl/rstcfg_pkg.sv
// Shared constants for the reset configuration sampler.
// Assumes the reset source code is 3 bits wide. Codes 6 and 7 are unused and
// are treated like refreshing sources.
package rstcfg_pkg;
    localparam int SRC_W  = 3;
    localparam int BOOT_W = 2;

    localparam logic [SRC_W-1:0] SRC_POWERON = 3'd0;
    localparam logic [SRC_W-1:0] SRC_PIN     = 3'd1;
    localparam logic [SRC_W-1:0] SRC_WDOG    = 3'd2;
    localparam logic [SRC_W-1:0] SRC_DEBUG   = 3'd3;
    localparam logic [SRC_W-1:0] SRC_SWSYS   = 3'd4;
    localparam logic [SRC_W-1:0] SRC_SWPIN   = 3'd5;

    localparam logic [BOOT_W-1:0] BOOT_DEFAULT = 2'b00;
    localparam logic              WKP_DEFAULT  = 1'b1;

    // True when a reset of this source must keep the stored pull setting
    function automatic logic keeps_pull(input logic [SRC_W-1:0] src);
        return (src == SRC_DEBUG) || (src == SRC_SWPIN);
    endfunction
endpackage

// File: rtl/rstcfg_timer.sv
// Reset-active window timer.
// Raises 'active' after an edge that sees 'req', and holds it for LEN cycles
// after the last request. Gives a one-cycle capture strobe in the cycle where
// LEAD cycles of the window remain. A request in that cycle wins over the strobe.
// Assumes LEN > LEAD >= 1.
module rstcfg_timer #(
    parameter int LEN  = 32,
    parameter int LEAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic active,
    output logic sample_stb
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST_CNT   = CW'(LEN - 1);
    localparam logic [CW-1:0] SAMPLE_CNT = CW'(LEN - LEAD);

    logic [CW-1:0] cnt;

    // Window counter: restart on request, count while active, drop at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (req) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST_CNT) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Capture strobe in the cycle where LEAD cycles of the window remain
    always_comb begin
        sample_stb = active && !req && (cnt == SAMPLE_CNT);
    end
endmodule

// File: rtl/rstcfg_src_track.sv
// Pending reset source tracker.
// Holds the source code of the most recent request until capture. Tells the
// capture stage whether the pull setting must be refreshed and whether the
// current request is a power-on request.
module rstcfg_src_track
    import rstcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [SRC_W-1:0] req_src,
    output logic [SRC_W-1:0] pend_src,
    output logic             pull_refresh,
    output logic             por_req
);
    // Keep the code of the last request; the newest request replaces it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_src <= SRC_POWERON;
        end else if (req) begin
            pend_src <= req_src;
        end
    end

    // Decide the per-source rules
    always_comb begin
        pull_refresh = !keeps_pull(pend_src);
        por_req      = req && (req_src == SRC_POWERON);
    end
endmodule

// File: rtl/rstcfg_capture.sv
// Reset status register.
// Loads the pull bit, the boot code and the source code on the capture strobe.
// A power-on request clears the pull bit and boot code to their defaults.
// Assumes the strobe and a request never come in the same cycle (the timer
// makes sure of that).
module rstcfg_capture
    import rstcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              por_req,
    input  logic              pull_refresh,
    input  logic [SRC_W-1:0]  pend_src,
    input  logic              wkp_pin,
    input  logic              cfg_en,
    input  logic [BOOT_W-1:0] boot_pins,
    output logic              stat_wkp,
    output logic [BOOT_W-1:0] stat_boot,
    output logic [SRC_W-1:0]  stat_src
);
    logic [BOOT_W-1:0] boot_sel;

    // Pick the qualified boot pins or the default code
    always_comb begin
        boot_sel = cfg_en ? boot_pins : BOOT_DEFAULT;
    end

    // Status register update: block reset, power-on clear, or capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_wkp  <= WKP_DEFAULT;
            stat_boot <= BOOT_DEFAULT;
            stat_src  <= SRC_POWERON;
        end else if (por_req) begin
            stat_wkp  <= WKP_DEFAULT;
            stat_boot <= BOOT_DEFAULT;
        end else if (sample_stb) begin
            if (pull_refresh) begin
                stat_wkp <= wkp_pin;
            end
            stat_boot <= boot_sel;
            stat_src  <= pend_src;
        end
    end
endmodule

// File: rtl/rstcfg_sampler.sv
// Reset configuration pin sampler, top level.
// Joins the window timer, the source tracker and the status register.
// Assumes rst_src is valid in every cycle where rst_req is high.
module rstcfg_sampler
    import rstcfg_pkg::*;
#(
    parameter int LEN  = 32,
    parameter int LEAD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic [SRC_W-1:0] rst_src,
    input  logic             cfg_en,
    input  logic [BOOT_W-1:0] boot_pins,
    input  logic             wkp_pin,
    output logic             rst_active,
    output logic             stat_wkp,
    output logic [BOOT_W-1:0] stat_boot,
    output logic [SRC_W-1:0] stat_src
);
    logic             sample_stb;
    logic [SRC_W-1:0] pend_src;
    logic             pull_refresh;
    logic             por_req;

    rstcfg_timer #(.LEN(LEN), .LEAD(LEAD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (rst_req),
        .active     (rst_active),
        .sample_stb (sample_stb)
    );

    rstcfg_src_track u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (rst_req),
        .req_src      (rst_src),
        .pend_src     (pend_src),
        .pull_refresh (pull_refresh),
        .por_req      (por_req)
    );

    rstcfg_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_stb   (sample_stb),
        .por_req      (por_req),
        .pull_refresh (pull_refresh),
        .pend_src     (pend_src),
        .wkp_pin      (wkp_pin),
        .cfg_en       (cfg_en),
        .boot_pins    (boot_pins),
        .stat_wkp     (stat_wkp),
        .stat_boot    (stat_boot),
        .stat_src     (stat_src)
    );
endmodule

// File: rtl/rstcfg_sampler_chk.sv
// Checker for rstcfg_sampler, attached with bind.
// Keeps its own count of cycles since the last request and its own copy of the
// pending source. It uses these to check the window and the capture rules at
// the ports of the top module.
module rstcfg_sampler_chk #(
    parameter int LEN  = 32,
    parameter int LEAD = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_req,
    input logic [2:0] rst_src,
    input logic       cfg_en,
    input logic [1:0] boot_pins,
    input logic       wkp_pin,
    input logic       rst_active,
    input logic       stat_wkp,
    input logic [1:0] stat_boot,
    input logic [2:0] stat_src
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] IDLE_CNT = CW'(LEN);
    localparam logic [CW-1:0] CAP_CNT  = CW'(LEN - LEAD);

    logic [CW-1:0] since_req;
    logic [2:0]    chk_src;
    logic          cap_now;
    logic          keep_now;

    // Count cycles since the last request; park at LEN when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_req <= IDLE_CNT;
            chk_src   <= 3'd0;
        end else if (rst_req) begin
            since_req <= '0;
            chk_src   <= rst_src;
        end else if (since_req != IDLE_CNT) begin
            since_req <= since_req + 1'b1;
        end
    end

    // Find the capture cycle and the keep rule from the checker's own state
    always_comb begin
        cap_now  = !rst_req && (since_req == CAP_CNT);
        keep_now = (chk_src == 3'd3) || (chk_src == 3'd5);
    end

    // R2, R3: the window is high exactly while fewer than LEN cycles have passed
    a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active == (since_req != IDLE_CNT));

    // R2: a request always opens the window
    a_r2_req_opens: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_active);

    // R4: refreshing sources store the pin value of the capture cycle
    a_r4_wkp_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_now && !keep_now) |=> (stat_wkp == $past(wkp_pin)));

    // R5: debug and software-external sources keep the pull bit
    a_r5_wkp_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_now && keep_now) |=> $stable(stat_wkp));

    // R6: the boot code follows the enable in the capture cycle
    a_r6_boot_default: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_now && !cfg_en) |=> (stat_boot == 2'b00));
    a_r6_boot_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_now && cfg_en) |=> (stat_boot == $past(boot_pins)));

    // R7: the stored source is the last requested one
    a_r7_src: assert property (@(posedge clk) disable iff (!rst_n)
        cap_now |=> (stat_src == chk_src));

    // R8: power-on request clears the pull bit and the boot code
    a_r8_por_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && rst_src == 3'd0) |=> (stat_wkp && stat_boot == 2'b00));

    // R9: status holds outside capture and power-on requests
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_now && !(rst_req && rst_src == 3'd0))
            |=> $stable({stat_wkp, stat_boot, stat_src}));
endmodule

bind rstcfg_sampler rstcfg_sampler_chk #(.LEN(LEN), .LEAD(LEAD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_req    (rst_req),
    .rst_src    (rst_src),
    .cfg_en     (cfg_en),
    .boot_pins  (boot_pins),
    .wkp_pin    (wkp_pin),
    .rst_active (rst_active),
    .stat_wkp   (stat_wkp),
    .stat_boot  (stat_boot),
    .stat_src   (stat_src)
);

// File: tb/rstcfg_sampler_test.sv
// Bench for rstcfg_sampler: directed corner cases followed by seeded random
// reset windows. Expected status comes from a model kept in the bench.
module rstcfg_sampler_test;
    localparam int LEN  = 32;
    localparam int LEAD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 1'b0;
    logic [2:0] rst_src = 3'd0;
    logic       cfg_en = 1'b0;
    logic [1:0] boot_pins = 2'b00;
    logic       wkp_pin = 1'b0;
    logic       rst_active;
    logic       stat_wkp;
    logic [1:0] stat_boot;
    logic [2:0] stat_src;

    int checks = 0;
    int errors = 0;

    logic       exp_wkp  = 1'b1;
    logic [1:0] exp_boot = 2'b00;
    logic [2:0] exp_src  = 3'd0;
    logic [2:0] pend     = 3'd0;

    always #2 clk = ~clk;   // 250 MHz

    rstcfg_sampler #(.LEN(LEN), .LEAD(LEAD)) uut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .rst_src(rst_src),
        .cfg_en(cfg_en), .boot_pins(boot_pins), .wkp_pin(wkp_pin),
        .rst_active(rst_active), .stat_wkp(stat_wkp),
        .stat_boot(stat_boot), .stat_src(stat_src)
    );

    function automatic logic src_keeps(input logic [2:0] s);
        return (s == 3'd3) || (s == 3'd5);
    endfunction

    function automatic logic [1:0] boot_expect(input logic en, input logic [1:0] p);
        return en ? p : 2'b00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_status(input string req);
        check(req, {7'd0, stat_wkp}, {7'd0, exp_wkp});
        check(req, {6'd0, stat_boot}, {6'd0, exp_boot});
        check(req, {5'd0, stat_src}, {5'd0, exp_src});
    endtask

    // Drive a request in the coming edge
    task automatic pulse_req(input logic [2:0] s);
        @(negedge clk);
        rst_req = 1'b1;
        rst_src = s;
        pend    = s;
        if (s == 3'd0) begin
            exp_wkp  = 1'b1;
            exp_boot = 2'b00;
        end
    endtask

    // Run k window cycles with random pins, no capture expected
    task automatic run_partial(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            rst_req   = 1'b0;
            wkp_pin   = 1'($urandom);
            cfg_en    = 1'($urandom);
            boot_pins = 2'($urandom);
            check("R3 active during restart", {7'd0, rst_active}, 8'd1);
            check_status("R9 hold before restart");
        end
    endtask

    // Full window; force_pin/force_en < 0 means random in the capture cycle
    task automatic run_window(input int force_pin, input int force_en, input int force_boot);
        logic cap_w;
        logic cap_e;
        logic [1:0] cap_b;
        cap_w = 1'b0; cap_e = 1'b0; cap_b = 2'b00;
        for (int i = 0; i <= LEN; i++) begin
            @(negedge clk);
            rst_req = 1'b0;
            if (i == 0) begin
                check("R2 active after request", {7'd0, rst_active}, 8'd1);
                if (pend == 3'd0) check_status("R8 power-on clear");
            end
            if (i == LEN - 1) check("R2 active last cycle", {7'd0, rst_active}, 8'd1);
            if (i == LEN) check("R2 active drops", {7'd0, rst_active}, 8'd0);
            if (i >= 1 && i <= LEN - LEAD) check_status("R9 hold before capture");
            if (i == LEN - LEAD + 1) begin
                check_status(src_keeps(exp_src) ? "R5/R6/R7 capture" : "R4/R6/R7 capture");
            end
            wkp_pin   = 1'($urandom);
            cfg_en    = 1'($urandom);
            boot_pins = 2'($urandom);
            if (i == LEN - LEAD) begin
                if (force_pin >= 0) wkp_pin = 1'(force_pin);
                if (force_en >= 0) cfg_en = 1'(force_en);
                if (force_boot >= 0) boot_pins = 2'(force_boot);
                cap_w = wkp_pin; cap_e = cfg_en; cap_b = boot_pins;
                if (!src_keeps(pend)) exp_wkp = cap_w;
                exp_boot = boot_expect(cap_e, cap_b);
                exp_src  = pend;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset active", {7'd0, rst_active}, 8'd0);
        check_status("R1 reset status");

        // Power-on, then external pin with boot enabled
        pulse_req(3'd0); run_window(0, 1, 3);
        pulse_req(3'd1); run_window(1, 1, 2);
        // R5: debug and software-external keep pull bit despite opposite pin
        pulse_req(3'd2); run_window(0, 1, 1);
        pulse_req(3'd3); run_window(1, 1, 3);
        pulse_req(3'd5); run_window(1, 0, 3);
        // R6: enable low with non-zero pins gives the default code
        pulse_req(3'd4); run_window(1, 0, 3);
        // R8: power-on after non-default values
        pulse_req(3'd0); run_window(0, 1, 2);
        // R3: restart in mid-window with a different source
        pulse_req(3'd1); run_partial(LEN - LEAD - 2);
        pulse_req(3'd2); run_window(1, 1, 1);
        pulse_req(3'd3); run_partial(5);
        pulse_req(3'd1); run_window(0, 0, 2);

        for (int n = 0; n < 40; n++) begin
            logic [2:0] s;
            s = 3'($urandom_range(0, 5));
            if ($urandom_range(0, 3) == 0) begin
                pulse_req(3'($urandom_range(0, 5)));
                run_partial(int'($urandom_range(1, LEN - LEAD - 1)));
            end
            pulse_req(s);
            run_window(-1, -1, -1);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule